// File: doc/BRIEF.md
# Privilege State Access Checker

This block holds the two machine-state bits of a core: a problem bit, set while unprivileged code runs, and a hypervisor bit. It derives the current privilege level from them and judges every request from the pipeline against that level. A request is either a special-register access, a write of new state bits, or an instruction fetch, load or store that hits a mapping carrying privilege restrictions. Each judged request gives either a grant or exactly one exception with a two-bit cause code. A privilege breach is reported as a program interrupt. A failed mapping check is reported as an instruction storage exception for a fetch, or as a data storage exception for a load or store.

The request side is a valid-only stream with no back-pressure. The block accepts one request on every cycle in which `req_valid` is high. The verdict for that request appears in the next cycle as a one-cycle `res_valid` pulse. A consumer that cannot take a verdict in that cycle must hold back its own requests, because nothing is buffered. Address translation, table walks and interrupt vectoring happen outside this block. The parameter `HV_EN` removes hypervisor support.

Top module: `priv_access_checker`

## Requirements
- R1: The `level` port encodes the current privilege level as follows. 0 is user and is shown whenever the problem bit is 1, whatever the hypervisor bit holds. 1 is supervisor, shown when both bits are 0. 2 is hypervisor, shown when the problem bit is 0 and the hypervisor bit is 1.
- R2: With `HV_EN`=0 the hypervisor bit always reads 0, even after a state write with `wr_hyp`=1. In that build the level is only ever 0 or 1, and a mapping marked hypervisor-only always fails its check.
- R3: A synchronous active-high `rst` sets the problem bit to 0. It sets the hypervisor bit to 1, or to 0 when `HV_EN`=0. It also clears `res_valid`.
- R4: A special-register access uses `req_class`=0. The register is privileged when `op_priv` is 1 or when `reg_idx` is at least `PRIV_BASE` (default 24). At user level, an access to a privileged register gives cause 1 and no grant. Every other special-register access is granted.
- R5: A state write uses `req_class`=1. Below user level it is granted, and `wr_prob`/`wr_hyp` become the state bits from the next cycle. At user level it gives cause 1, and both state bits keep their values.
- R6: Fetch, load and store use `req_class` 2, 3 and 4. `map_sup_only`=1 fails at user level. `map_hyp_only`=1 fails at any level other than hypervisor. A mapping with neither flag set passes at every level.
- R7: A failed mapping check gives cause 2 with `exc_istor` for a fetch, and cause 3 with `exc_dstor` for a load or store.
- R8: For a fetch, load or store, `op_priv`=1 at user level gives cause 1. Cause 1 wins over a mapping failure in the same request.
- R9: `res_valid` rises exactly one cycle after each cycle with `req_valid`=1 and is 0 otherwise. While `res_valid` is 1, exactly one of `res_grant`, `exc_prog`, `exc_istor`, `exc_dstor` is 1. While it is 0, all four are 0.
- R10: `res_cause` is 0 with a grant, 1 with `exc_prog`, 2 with `exc_istor` and 3 with `exc_dstor`.
- R11: A `req_class` value of 5 to 7 is not defined. It gives cause 1 at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 3 | 0 special register, 1 state write, 2 fetch, 3 load, 4 store |
| reg_idx | input | REG_W | Special-register index |
| op_priv | input | 1 | Request is a privileged operation |
| map_sup_only | input | 1 | Mapping usable only with problem bit 0 |
| map_hyp_only | input | 1 | Mapping usable only at hypervisor level |
| wr_prob | input | 1 | New problem bit for a state write |
| wr_hyp | input | 1 | New hypervisor bit for a state write |
| res_valid | output | 1 | Verdict pulse, one cycle after the request |
| res_grant | output | 1 | Request granted |
| exc_prog | output | 1 | Program interrupt |
| exc_istor | output | 1 | Instruction storage exception |
| exc_dstor | output | 1 | Data storage exception |
| res_cause | output | 2 | Cause code |
| level | output | 2 | Current privilege level |
| state_prob | output | 1 | Problem bit |
| state_hyp | output | 1 | Hypervisor bit |

## Verification
A privilege breach and a mapping failure can both apply to the same request. The bench provokes this with a load or store that sets `op_priv` and also hits a supervisor-only or hypervisor-only mapping while at user level, and it expects only the program cause. It also sends a state write in one cycle and a check that depends on the new level in the next cycle, so the bench sees whether the new level takes effect exactly one edge later. A scoreboard with its own level model compares every verdict, and it is run against a build with hypervisor support and a build without it.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;
  typedef enum logic [1:0] {LVL_USER = 2'd0, LVL_SUP = 2'd1, LVL_HYP = 2'd2} lvl_e;
  typedef enum logic [2:0] {
    RQ_SREG = 3'd0, RQ_STWR = 3'd1, RQ_FETCH = 3'd2, RQ_LOAD = 3'd3, RQ_STORE = 3'd4
  } rq_e;
  typedef enum logic [1:0] {CS_NONE = 2'd0, CS_PROG = 2'd1, CS_ISTOR = 2'd2, CS_DSTOR = 2'd3} cause_e;
  typedef struct packed {
    logic   grant;
    cause_e cause;
  } verdict_t;
endpackage

// File: rtl/priv_state_reg.sv
module priv_state_reg #(
  parameter bit HV_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic nxt_prob,
  input  logic nxt_hyp,
  output logic prob,
  output logic hyp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prob <= 1'b0;
      hyp  <= HV_EN;
    end else if (upd) begin
      prob <= nxt_prob;
      hyp  <= nxt_hyp & HV_EN;
    end
  end

  // R2
  hyp_absent_chk: assert property (@(posedge clk) disable iff (rst) !HV_EN |-> !hyp);
endmodule

// File: rtl/priv_level_decode.sv
module priv_level_decode
  import priv_chk_pkg::*;
#(
  parameter bit HV_EN = 1'b1
) (
  input  logic prob,
  input  logic hyp,
  output lvl_e lvl
);
  always_comb begin
    if (prob)                lvl = LVL_USER;
    else if (hyp && HV_EN)   lvl = LVL_HYP;
    else                     lvl = LVL_SUP;
  end
endmodule

// File: rtl/priv_rule_check.sv
module priv_rule_check
  import priv_chk_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int PRIV_BASE = 24
) (
  input  lvl_e             lvl,
  input  logic [2:0]       cls,
  input  logic [REG_W-1:0] reg_idx,
  input  logic             op_priv,
  input  logic             map_sup_only,
  input  logic             map_hyp_only,
  output verdict_t         vd
);
  localparam logic [REG_W-1:0] PB = PRIV_BASE[REG_W-1:0];

  logic is_user, prog_f, stor_f, is_mem;

  always_comb begin
    is_user = (lvl == LVL_USER);
    prog_f  = 1'b0;
    stor_f  = 1'b0;
    is_mem  = (cls == RQ_FETCH) || (cls == RQ_LOAD) || (cls == RQ_STORE);
    if (cls == RQ_SREG) begin
      prog_f = is_user && (op_priv || (reg_idx >= PB));
    end else if (cls == RQ_STWR) begin
      prog_f = is_user;
    end else if (is_mem) begin
      prog_f = is_user && op_priv;
      stor_f = (map_sup_only && is_user) || (map_hyp_only && (lvl != LVL_HYP));
    end else begin
      prog_f = 1'b1;
    end

    if (prog_f)      vd = '{grant: 1'b0, cause: CS_PROG};
    else if (stor_f) vd = '{grant: 1'b0, cause: (cls == RQ_FETCH) ? CS_ISTOR : CS_DSTOR};
    else             vd = '{grant: 1'b1, cause: CS_NONE};
  end
endmodule

// File: rtl/priv_access_checker.sv
module priv_access_checker
  import priv_chk_pkg::*;
#(
  parameter bit HV_EN     = 1'b1,
  parameter int REG_W     = 5,
  parameter int PRIV_BASE = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_class,
  input  logic [REG_W-1:0] reg_idx,
  input  logic             op_priv,
  input  logic             map_sup_only,
  input  logic             map_hyp_only,
  input  logic             wr_prob,
  input  logic             wr_hyp,
  output logic             res_valid,
  output logic             res_grant,
  output logic             exc_prog,
  output logic             exc_istor,
  output logic             exc_dstor,
  output logic [1:0]       res_cause,
  output logic [1:0]       level,
  output logic             state_prob,
  output logic             state_hyp
);
  lvl_e     lvl;
  verdict_t vd;
  cause_e   cause_q;
  logic     upd;

  assign upd = req_valid && (req_class == RQ_STWR) && vd.grant;

  priv_state_reg #(.HV_EN(HV_EN)) u_state (
    .clk(clk), .rst(rst), .upd(upd), .nxt_prob(wr_prob), .nxt_hyp(wr_hyp),
    .prob(state_prob), .hyp(state_hyp)
  );

  priv_level_decode #(.HV_EN(HV_EN)) u_dec (
    .prob(state_prob), .hyp(state_hyp), .lvl(lvl)
  );

  priv_rule_check #(.REG_W(REG_W), .PRIV_BASE(PRIV_BASE)) u_rule (
    .lvl(lvl), .cls(req_class), .reg_idx(reg_idx), .op_priv(op_priv),
    .map_sup_only(map_sup_only), .map_hyp_only(map_hyp_only), .vd(vd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      cause_q   <= CS_NONE;
    end else begin
      res_valid <= req_valid;
      res_grant <= req_valid && vd.grant;
      cause_q   <= req_valid ? vd.cause : CS_NONE;
    end
  end

  assign res_cause = cause_q;
  assign exc_prog  = (cause_q == CS_PROG);
  assign exc_istor = (cause_q == CS_ISTOR);
  assign exc_dstor = (cause_q == CS_DSTOR);
  assign level     = lvl;

  // R1
  user_level_chk: assert property (@(posedge clk) disable iff (rst) state_prob |-> level == 2'd0);
  // R5
  locked_state_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_class == 3'd1 && state_prob) |=> ($stable(state_prob) && $stable(state_hyp)));
  // R8
  prog_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && state_prob && op_priv) |=> exc_prog);
  // R9
  pulse_follow_chk: assert property (@(posedge clk) disable iff (rst) req_valid |=> res_valid);
  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !res_valid);
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_grant, exc_prog, exc_istor, exc_dstor}));
  // R10
  grant_code_chk: assert property (@(posedge clk) disable iff (rst) res_grant |-> res_cause == 2'd0);
endmodule

// File: tb/priv_access_checker_tb.sv
module priv_access_checker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_class = 3'd0;
  logic [4:0] reg_idx = 5'd0;
  logic op_priv = 1'b0, map_sup_only = 1'b0, map_hyp_only = 1'b0;
  logic wr_prob = 1'b0, wr_hyp = 1'b0;

  logic a_v, a_g, a_p, a_i, a_d, a_sp, a_sh;
  logic [1:0] a_c, a_l;
  logic b_v, b_g, b_p, b_i, b_d, b_sp, b_sh;
  logic [1:0] b_c, b_l;

  int total = 0, bad = 0, cyc = 0;

  typedef struct {
    int    stamp;
    bit    g;
    bit [1:0] c;
    string tag;
  } exp_t;
  exp_t qa[$];
  exp_t qb[$];

  bit ma_p = 0, ma_h = 1, mb_p = 0, mb_h = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  priv_access_checker #(.HV_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class), .reg_idx(reg_idx),
    .op_priv(op_priv), .map_sup_only(map_sup_only), .map_hyp_only(map_hyp_only),
    .wr_prob(wr_prob), .wr_hyp(wr_hyp), .res_valid(a_v), .res_grant(a_g), .exc_prog(a_p),
    .exc_istor(a_i), .exc_dstor(a_d), .res_cause(a_c), .level(a_l),
    .state_prob(a_sp), .state_hyp(a_sh)
  );

  priv_access_checker #(.HV_EN(1'b0)) u_dut_nohv (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class), .reg_idx(reg_idx),
    .op_priv(op_priv), .map_sup_only(map_sup_only), .map_hyp_only(map_hyp_only),
    .wr_prob(wr_prob), .wr_hyp(wr_hyp), .res_valid(b_v), .res_grant(b_g), .exc_prog(b_p),
    .exc_istor(b_i), .exc_dstor(b_d), .res_cause(b_c), .level(b_l),
    .state_prob(b_sp), .state_hyp(b_sh)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(bit hv, bit p, bit h);
    return p ? 0 : ((hv && h) ? 2 : 1);
  endfunction

  function automatic bit [2:0] judge(bit hv, bit p, bit h, bit [2:0] c, bit [4:0] idx,
                                     bit op, bit ms, bit mh);
    int lv = lvl_of(hv, p, h);
    bit usr = (lv == 0);
    bit pf = 0, sf = 0;
    if (c == 0) pf = usr && (op || idx >= 5'd24);
    else if (c == 1) pf = usr;
    else if (c <= 4) begin
      pf = usr && op;
      sf = (ms && usr) || (mh && lv != 2);
    end else pf = 1;
    if (pf) return {1'b0, 2'd1};
    if (sf) return {1'b0, (c == 2) ? 2'd2 : 2'd3};
    return {1'b1, 2'd0};
  endfunction

  task automatic send(input bit [2:0] c, input bit [4:0] idx, input bit op, input bit ms,
                      input bit mh, input bit wp, input bit wh, input string tag);
    bit [2:0] ra, rb;
    @(negedge clk);
    check(a_l == 2'(lvl_of(1, ma_p, ma_h)), {tag, " R1 level"}, a_l, lvl_of(1, ma_p, ma_h));
    check(b_l == 2'(lvl_of(0, mb_p, mb_h)), {tag, " R2 level nohv"}, b_l, lvl_of(0, mb_p, mb_h));
    check(b_sh == 1'b0, {tag, " R2 hyp bit nohv"}, b_sh, 0);
    req_valid = 1'b1; req_class = c; reg_idx = idx; op_priv = op;
    map_sup_only = ms; map_hyp_only = mh; wr_prob = wp; wr_hyp = wh;
    ra = judge(1, ma_p, ma_h, c, idx, op, ms, mh);
    rb = judge(0, mb_p, mb_h, c, idx, op, ms, mh);
    qa.push_back('{cyc, ra[2], ra[1:0], tag});
    qb.push_back('{cyc, rb[2], rb[1:0], {tag, " nohv"}});
    if (c == 1 && ra[2]) begin ma_p = wp; ma_h = wh; end
    if (c == 1 && rb[2]) begin mb_p = wp; mb_h = 1'b0; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic mon_one(input logic v, input logic g, input logic p, input logic ii,
                         input logic d, input logic [1:0] c, ref exp_t q[$], input string who);
    if (q.size() > 0 && q[0].stamp + 1 == cyc) begin
      exp_t e = q.pop_front();
      check(v == 1'b1, {e.tag, " R9 valid"}, v, 1);
      check(g == e.g, {e.tag, " grant R4 R5 R6"}, g, e.g);
      check(c == e.c, {e.tag, " cause R7 R8 R11"}, c, e.c);
      check({p, ii, d} == {e.c == 2'd1, e.c == 2'd2, e.c == 2'd3}, {e.tag, " R10 flags"},
            {p, ii, d}, {e.c == 2'd1, e.c == 2'd2, e.c == 2'd3});
    end else if (v) begin
      check(1'b0, {who, " R9 unexpected pulse"}, v, 0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      mon_one(a_v, a_g, a_p, a_i, a_d, a_c, qa, "hv");
      mon_one(b_v, b_g, b_p, b_i, b_d, b_c, qb, "nohv");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(a_sp == 0 && a_sh == 1, "R3 reset state hv", {a_sp, a_sh}, 1);
    check(b_sp == 0 && b_sh == 0, "R3 reset state nohv", {b_sp, b_sh}, 0);
    check(a_v == 0 && b_v == 0, "R3 no pulse after reset", a_v, 0);

    send(0, 5'd3,  0, 0, 0, 0, 0, "R4 sreg low hyp");
    send(0, 5'd30, 0, 0, 0, 0, 0, "R4 sreg high hyp");
    send(3, 5'd0,  0, 0, 1, 0, 0, "R6 load hyp-only");
    send(1, 5'd0,  0, 0, 0, 0, 0, "R5 write to sup");
    send(2, 5'd0,  0, 0, 1, 0, 0, "R7 fetch hyp-only at sup");
    send(4, 5'd0,  0, 1, 0, 0, 0, "R6 store sup-only at sup");
    send(1, 5'd0,  0, 0, 0, 0, 1, "R2 write hyp");
    send(3, 5'd0,  0, 0, 1, 0, 0, "R2 load hyp-only");
    send(1, 5'd0,  0, 0, 0, 1, 1, "R5 write to user");
    send(0, 5'd3,  0, 0, 0, 0, 0, "R4 sreg low user");
    send(0, 5'd24, 0, 0, 0, 0, 0, "R4 sreg base user");
    send(0, 5'd23, 0, 0, 0, 0, 0, "R4 sreg below base user");
    send(0, 5'd2,  1, 0, 0, 0, 0, "R4 op_priv user");
    send(1, 5'd0,  0, 0, 0, 0, 0, "R5 write denied user");
    send(2, 5'd0,  0, 1, 0, 0, 0, "R7 fetch sup-only user");
    send(3, 5'd0,  0, 1, 0, 0, 0, "R7 load sup-only user");
    send(4, 5'd0,  0, 0, 1, 0, 0, "R7 store hyp-only user");
    send(4, 5'd0,  0, 0, 0, 0, 0, "R6 store plain user");
    send(3, 5'd0,  1, 1, 0, 0, 0, "R8 load priv+map user");
    send(2, 5'd0,  1, 0, 1, 0, 0, "R8 fetch priv+map user");
    send(5, 5'd0,  0, 0, 0, 0, 0, "R11 class5 user");
    idle(3);
    check(a_sp == 1 && a_sh == 1, "R5 state kept after denied write", {a_sp, a_sh}, 3);

    @(negedge clk); rst = 1'b1;
    ma_p = 0; ma_h = 1; mb_p = 0; mb_h = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(a_l == 2'd2, "R3 level after second reset", a_l, 2);
    check(b_l == 2'd1, "R3 level nohv after second reset", b_l, 1);
    send(7, 5'd0, 0, 0, 0, 0, 0, "R11 class7 hyp");
    send(1, 5'd0, 0, 0, 0, 1, 0, "R5 write to user again");
    send(0, 5'd31, 0, 0, 0, 0, 0, "R4 sreg top user next cycle");
    idle(3);
    check(qa.size() == 0 && qb.size() == 0, "R9 all verdicts seen", qa.size() + qb.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule